// File: doc/BRIEF.md
# Accumulate and Moving-Sum Decimation Filter

This block thins out one stream of converter samples in two stages. Samples arrive on a data bus with a valid strobe and a channel tag. Only samples from the channel that the configuration selects are used. The first stage adds a programmable number of consecutive accepted samples into an intermediate result. The second stage adds each new intermediate result to a short, shifting history of earlier ones, which gives a moving-sum final result.

An interrupt flag pulses each time the final result updates. The running partial sum, the addition counter, the history entries and the final result are all driven onto output ports. Every register starts at zero, so the first final results cover fewer intermediate results until the history fills. Configuration comes from static inputs. Changing the configuration, or raising the clear input, resets all filter state to zero. No scaling or division is applied to the final sum.

Top module: `accfilt_top`

## Requirements
- R1: After reset, `curSum`, `addCount`, every history entry and `finalSum` are zero, and `irqFlag` is low.
- R2: A sample enters the filter only when `sampleValid` is 1, `inSel[2]` is 1 and `sampleChan` equals `inSel[1:0]`. Any other sample leaves every output unchanged. With `inSel[2]` at 0, no sample is used.
- R3: On an accepted sample, `curSum` loads the sample when `addCount` is 0. Otherwise it adds the sample to its previous value, so a group reads CV0, CV0+CV1, CV0+CV1+CV2 and so on.
- R4: `addCount` steps by one on each accepted sample, from 0 up to `addLen`, then returns to 0. A group therefore holds `addLen`+1 samples.
- R5: When a group completes, the history shifts by one place. Entry 0 (bits 12:0 of `histOut`) takes the completed intermediate result, entry 1 (bits 25:13) takes the old entry 0, and entry 2 (bits 38:26) takes the old entry 1.
- R6: When a group completes, `finalSum` becomes the new intermediate result plus the first `mavLen` history entries as they stood before the shift. Code 0 uses no history entries and code 3 uses all three, so the final result covers `mavLen`+1 intermediate results.
- R7: `irqFlag` is high for exactly one cycle. It follows each completed group, on the same edge that `finalSum` updates, and at no other time.
- R8: When `inSel`, `addLen` or `mavLen` differs from its value in the previous cycle, all filter state returns to zero on that edge, and a sample offered in that cycle is ignored.
- R9: When `clear_i` is 1, all filter state returns to zero on that edge, and a sample offered in that cycle is ignored.
- R10: With `addLen` at 7, `mavLen` at 3 and every sample at 1023, neither sum wraps: the intermediate result reaches 8184 and `finalSum` reaches 32736.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of all filter state |
| sampleValid | input | 1 | Sample strobe |
| sampleData | input | 10 | Unsigned converter sample |
| sampleChan | input | 2 | Channel tag of the sample |
| inSel | input | 3 | Source select: bit 2 enables, bits 1:0 give the channel |
| addLen | input | 3 | Samples per group, minus one |
| mavLen | input | 2 | History entries added to the final result |
| curSum | output | 13 | Running partial sum |
| addCount | output | 3 | Position within the current group |
| histOut | output | 39 | Three 13-bit history entries, entry 0 in the low bits |
| finalSum | output | 16 | Moving-sum final result |
| irqFlag | output | 1 | One-cycle pulse on each final result update |

## Verification
The bench uses the four-by-four setting from all-zero registers and checks that the first final results cover one, two, three and then four intermediate results. A design that ignored the history start state, or added the history after the shift, would give the wrong values here. The shortest group (`addLen` 0) and the longest group at full-scale input are both run: an off-by-one counter would misplace group boundaries, and a narrow sum would wrap. Moving-sum codes 0 to 2 are checked for excluded entries leaking into the sum. Non-matching channels, invalid strobes and a cleared enable bit are offered between accepted samples. A clear or configuration change is offered together with a sample, to catch designs that still take that sample or clear only part of the state.

// File: rtl/accfilt_pkg.sv
package accfilt_pkg;
  // Strobes from control to datapath, all valid in the current cycle
  typedef struct packed {
    logic clearAll;  // zero every register this edge
    logic accept;    // a selected sample is present
    logic first;     // sample starts a new group
    logic complete;  // sample closes the current group
  } filt_strobe_t;
endpackage

// File: rtl/accfilt_ctrl.sv
module accfilt_ctrl
  import accfilt_pkg::*;
#(
  parameter int CHAN_W = 2,
  parameter int LEN_W  = 3,
  parameter int MAV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              sampleValid,
  input  logic [CHAN_W-1:0] sampleChan,
  input  logic [CHAN_W:0]   inSel,
  input  logic [LEN_W-1:0]  addLen,
  input  logic [MAV_W-1:0]  mavLen,
  output filt_strobe_t      strb,
  output logic [LEN_W-1:0]  addCount
);
  localparam int CFG_W = CHAN_W + 1 + LEN_W + MAV_W;

  logic [CFG_W-1:0] cfgNow;
  logic [CFG_W-1:0] cfgPrev;
  logic             cfgChanged;
  logic             chanHit;

  assign cfgNow     = {inSel, addLen, mavLen};
  assign cfgChanged = (cfgNow != cfgPrev);
  assign chanHit    = inSel[CHAN_W] && (sampleChan == inSel[CHAN_W-1:0]);

  always_comb begin
    strb.clearAll = clear_i || cfgChanged;
    strb.accept   = sampleValid && chanHit && !strb.clearAll;
    strb.first    = (addCount == '0);
    strb.complete = strb.accept && (addCount == addLen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgPrev  <= '0;
      addCount <= '0;
    end else begin
      cfgPrev <= cfgNow;
      if (strb.clearAll)      addCount <= '0;
      else if (strb.complete) addCount <= '0;
      else if (strb.accept)   addCount <= addCount + 1'b1;
    end
  end

  // R4: counter never passes the programmed group end
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.clearAll |-> (addCount <= addLen));

  // R8: a configuration change leaves the counter at zero
  a_r8_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfgChanged |=> (addCount == '0));

  // R2: no sample is taken while the enable bit is clear
  a_r2_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !inSel[CHAN_W] |-> !strb.accept);
endmodule

// File: rtl/accfilt_dpath.sv
module accfilt_dpath
  import accfilt_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int LEN_W    = 3,
  parameter int MAV_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  filt_strobe_t              strb,
  input  logic [SAMPLE_W-1:0]       sampleData,
  input  logic [MAV_W-1:0]          mavLen,
  output logic [SAMPLE_W+LEN_W-1:0] curSum,
  output logic [(2**MAV_W-1)*(SAMPLE_W+LEN_W)-1:0] histOut,
  output logic [SAMPLE_W+LEN_W+MAV_W:0] finalSum,
  output logic                      irqFlag
);
  localparam int IR_W   = SAMPLE_W + LEN_W;
  localparam int HIST_N = 2**MAV_W - 1;
  localparam int FIN_W  = IR_W + MAV_W + 1;

  logic [IR_W-1:0]  hist [HIST_N];
  logic [IR_W:0]    sumWide;
  logic [IR_W-1:0]  nextSum;
  logic [FIN_W-1:0] histTotal;
  logic [FIN_W-1:0] nextFinal;

  // stage one: running group sum, one guard bit to observe overflow
  always_comb begin
    if (strb.first) sumWide = {{(LEN_W+1){1'b0}}, sampleData};
    else            sumWide = {1'b0, curSum} + {{(LEN_W+1){1'b0}}, sampleData};
    nextSum = sumWide[IR_W-1:0];
  end

  // stage two: add only the history entries the moving-sum code asks for
  always_comb begin
    histTotal = '0;
    for (int i = 0; i < HIST_N; i++) begin
      if (i < int'(mavLen)) histTotal = histTotal + FIN_W'(hist[i]);
    end
    nextFinal = histTotal + FIN_W'(nextSum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curSum   <= '0;
      finalSum <= '0;
      irqFlag  <= 1'b0;
    end else if (strb.clearAll) begin
      curSum   <= '0;
      finalSum <= '0;
      irqFlag  <= 1'b0;
    end else begin
      irqFlag <= strb.complete;
      if (strb.accept)   curSum   <= nextSum;
      if (strb.complete) finalSum <= nextFinal;
    end
  end

  // history shift register, entry 0 newest
  for (genvar g = 0; g < HIST_N; g++) begin : gHist
    logic [IR_W-1:0] shiftIn;
    if (g == 0) begin : gHead
      assign shiftIn = nextSum;
    end else begin : gTail
      assign shiftIn = hist[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             hist[g] <= '0;
      else if (strb.clearAll) hist[g] <= '0;
      else if (strb.complete) hist[g] <= shiftIn;
    end
    assign histOut[g*IR_W +: IR_W] = hist[g];
  end

  // R1/R9: a clear zeroes the visible state
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearAll |=> (curSum == '0 && finalSum == '0 && histOut == '0 && !irqFlag));

  // R5: on each group completion older entries move down one place
  a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
    irqFlag |-> (histOut[2*IR_W-1:IR_W] == $past(histOut[IR_W-1:0])));

  // R2: nothing moves without an accepted sample
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.accept && !strb.clearAll) |=> ($stable(curSum) && $stable(finalSum) && $stable(histOut)));

  // R7: the final result only moves together with the flag
  a_r7_final_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((finalSum != $past(finalSum)) && !$past(strb.clearAll)) |-> irqFlag);

  // R10: the group sum never needs the guard bit
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    strb.accept |-> !sumWide[IR_W]);
endmodule

// File: rtl/accfilt_top.sv
module accfilt_top
  import accfilt_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int CHAN_W   = 2,
  parameter int LEN_W    = 3,
  parameter int MAV_W    = 2,
  localparam int IR_W    = SAMPLE_W + LEN_W,
  localparam int HIST_N  = 2**MAV_W - 1,
  localparam int FIN_W   = IR_W + MAV_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic                   sampleValid,
  input  logic [SAMPLE_W-1:0]    sampleData,
  input  logic [CHAN_W-1:0]      sampleChan,
  input  logic [CHAN_W:0]        inSel,
  input  logic [LEN_W-1:0]       addLen,
  input  logic [MAV_W-1:0]       mavLen,
  output logic [IR_W-1:0]        curSum,
  output logic [LEN_W-1:0]       addCount,
  output logic [HIST_N*IR_W-1:0] histOut,
  output logic [FIN_W-1:0]       finalSum,
  output logic                   irqFlag
);
  filt_strobe_t strb;

  accfilt_ctrl #(.CHAN_W(CHAN_W), .LEN_W(LEN_W), .MAV_W(MAV_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .sampleValid(sampleValid),
    .sampleChan(sampleChan), .inSel(inSel), .addLen(addLen), .mavLen(mavLen),
    .strb(strb), .addCount(addCount)
  );

  accfilt_dpath #(.SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W), .MAV_W(MAV_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .sampleData(sampleData),
    .mavLen(mavLen), .curSum(curSum), .histOut(histOut),
    .finalSum(finalSum), .irqFlag(irqFlag)
  );
endmodule

// File: tb/accfilt_top_tb_top.sv
`timescale 1ns/1ps
module accfilt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear_i = 1'b0;
  logic        sampleValid = 1'b0;
  logic [9:0]  sampleData = '0;
  logic [1:0]  sampleChan = '0;
  logic [2:0]  inSel = '0;
  logic [2:0]  addLen = '0;
  logic [1:0]  mavLen = '0;
  logic [12:0] curSum;
  logic [2:0]  addCount;
  logic [38:0] histOut;
  logic [15:0] finalSum;
  logic        irqFlag;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  // bench model state
  int mCur, mCnt, mFin, mIrq;
  int mH [3];

  always #2 clk = ~clk;  // 250 MHz

  accfilt_top dut_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .sampleValid(sampleValid),
    .sampleData(sampleData), .sampleChan(sampleChan), .inSel(inSel),
    .addLen(addLen), .mavLen(mavLen), .curSum(curSum), .addCount(addCount),
    .histOut(histOut), .finalSum(finalSum), .irqFlag(irqFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelZero();
    mCur = 0; mCnt = 0; mFin = 0; mIrq = 0;
    for (int i = 0; i < 3; i++) mH[i] = 0;
  endtask

  task automatic checkAll(input string ctx);
    chk({ctx, " R3 curSum"}, 32'(curSum), 32'(mCur));
    chk({ctx, " R4 addCount"}, 32'(addCount), 32'(mCnt));
    chk({ctx, " R5 hist0"}, 32'(histOut[12:0]), 32'(mH[0]));
    chk({ctx, " R5 hist1"}, 32'(histOut[25:13]), 32'(mH[1]));
    chk({ctx, " R5 hist2"}, 32'(histOut[38:26]), 32'(mH[2]));
    chk({ctx, " R6 finalSum"}, 32'(finalSum), 32'(mFin));
    chk({ctx, " R7 irqFlag"}, 32'(irqFlag), 32'(mIrq));
  endtask

  // offer one sample for one cycle and compare against the model
  task automatic feed(input int d, input int ch, input bit v, input string ctx);
    int ir;
    @(negedge clk);
    sampleValid = v; sampleData = 10'(d); sampleChan = 2'(ch);
    @(posedge clk);
    #1;
    mIrq = 0;
    if (v && inSel[2] && (ch == int'(inSel[1:0]))) begin
      mCur = (mCnt == 0) ? d : mCur + d;
      if (mCnt == int'(addLen)) begin
        ir = mCur;
        mFin = ir;
        for (int i = 0; i < 3; i++) if (i < int'(mavLen)) mFin += mH[i];
        mH[2] = mH[1]; mH[1] = mH[0]; mH[0] = ir;
        mIrq = 1; mCnt = 0;
      end else mCnt++;
    end
    checkAll(ctx);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // apply a new configuration, optionally with a sample at the same time
  task automatic setCfg(input int s, input int a, input int m, input bit withSample);
    @(negedge clk);
    inSel = 3'(s); addLen = 3'(a); mavLen = 2'(m);
    sampleValid = withSample; sampleData = 10'd77; sampleChan = 2'(s);
    @(posedge clk);
    #1;
    modelZero();
    checkAll("R8 cfg change");
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic testReset();
    modelZero();
    checkAll("R1 reset");
  endtask

  // four samples per group, four-entry moving sum, from zero registers
  task automatic testFourByFour();
    int total = 0;
    setCfg(3'b101, 3, 3, 1'b0);
    for (int k = 0; k < 16; k++) begin
      feed(k + 1, 1, 1'b1, "R3 four-by-four");
      total += k + 1;
      if (k == 3)  chk("R6 first output is IR1", 32'(finalSum), 32'd10);
      if (k == 7)  chk("R6 second output IR1+IR2", 32'(finalSum), 32'd36);
    end
    chk("R6 full window equals all 16 samples", 32'(finalSum), 32'(total));
    for (int k = 0; k < 8; k++) feed(100 + k, 1, 1'b1, "R6 sliding window");
  endtask

  task automatic testChannel();
    setCfg(3'b110, 2, 3, 1'b0);
    for (int k = 0; k < 12; k++) begin
      feed(5 + k, 2, 1'b1, "R2 match");
      feed(900, k % 4 == 2 ? 3 : k % 4, 1'b1, "R2 other channel");
      feed(800, 2, 1'b0, "R2 invalid strobe");
    end
    setCfg(3'b010, 2, 3, 1'b0);
    for (int k = 0; k < 4; k++) feed(300, 2, 1'b1, "R2 select disabled");
    chk("R2 disabled curSum stays zero", 32'(curSum), 32'd0);
  endtask

  task automatic testMavCodes();
    for (int m = 0; m < 3; m++) begin
      setCfg(3'b100, 1, m, 1'b0);
      for (int k = 0; k < 12; k++) feed(10 * k + m + 1, 0, 1'b1, "R6 mav code");
    end
  endtask

  task automatic testLengths();
    setCfg(3'b111, 0, 2, 1'b0);
    for (int k = 0; k < 6; k++) begin
      feed(k * 3 + 1, 3, 1'b1, "R4 single-sample group");
      chk("R7 irq every sample", 32'(irqFlag), 32'd1);
    end
    setCfg(3'b111, 7, 3, 1'b0);
    for (int k = 0; k < 32; k++) feed(1023, 3, 1'b1, "R10 full scale");
    chk("R10 intermediate max", 32'(histOut[12:0]), 32'd8184);
    chk("R10 final max", 32'(finalSum), 32'd32736);
  endtask

  task automatic testClear();
    setCfg(3'b101, 3, 3, 1'b0);
    for (int k = 0; k < 6; k++) feed(50 + k, 1, 1'b1, "R9 pre clear");
    @(negedge clk);
    clear_i = 1'b1; sampleValid = 1'b1; sampleData = 10'd999; sampleChan = 2'd1;
    @(posedge clk);
    #1;
    modelZero();
    checkAll("R9 clear");
    @(negedge clk);
    clear_i = 1'b0; sampleValid = 1'b0;
    feed(7, 1, 1'b1, "R9 restart after clear");
    for (int k = 0; k < 5; k++) feed(60 + k, 1, 1'b1, "R8 pre change");
    setCfg(3'b101, 2, 3, 1'b1);  // sample offered in the change cycle
    for (int k = 0; k < 6; k++) feed(20 + k, 1, 1'b1, "R8 after change");
  endtask

  initial begin
    modelZero();
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testFourByFour();
    testChannel();
    testMavCodes();
    testLengths();
    testClear();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule